// File: doc/BRIEF.md
# Packed Sample FIFO Read Port

This block is a bus-slave read port that drains a FIFO of packed, interleaved multichannel ADC samples. Each FIFO word holds two 16-bit two's complement samples: the earlier channel in bits 31:16 and the next channel in bits 15:0. An upstream stage pushes one packed pair per valid cycle through a write port. Upstream only releases sample data after the pre-trigger part of the record has been located.

The host drains the FIFO through two register offsets. In 16-bit access mode, offset 0x08 returns the earlier channel of the head word and offset 0x0A returns the later channel. Only the 0x0A read pops the word, so the host reads 0x08 first. In 32-bit access mode, a read at either offset returns the whole head word and pops it. For four channels, two reads therefore give channels 1/2 and then 3/4.

Read data appears one cycle after the access. Reading an empty FIFO raises a sticky underflow flag.

Top module: `smp_fifo_rd_port`

## Requirements
- R1: After reset, empty_o=1, full_o=0, rvalid_o=0, rdata_o=0 and underflow_o=0.
- R2: A word on wr_data_i is stored when wr_valid_i=1 and full_o=0. A write while full_o=1 is dropped. full_o=1 exactly when DEPTH words are held.
- R3: A 16-bit read (d32_i=0) at offset 0x08 returns bits 31:16 of the head word in rdata_o[15:0] with rdata_o[31:16]=0. It does not advance the FIFO.
- R4: A 16-bit read at offset 0x0A returns bits 15:0 of the head word in rdata_o[15:0] with rdata_o[31:16]=0. It then pops the head word.
- R5: A 32-bit read (d32_i=1) at offset 0x08 or 0x0A returns the whole head word, with the earlier channel in bits 31:16. It then pops the head word.
- R6: A read at any offset other than 0x08 or 0x0A returns zero. It changes neither the FIFO contents nor the flags.
- R7: rvalid_o is 1 in the cycle after a cycle with rd_en_i=1 and 0 otherwise. rdata_o is zero whenever rvalid_o is 0.
- R8: A read at 0x08 or 0x0A while the FIFO is empty returns zero, does not move the read pointer and sets underflow_o. underflow_o stays set until uf_clr_i=1, and a new underflow in the same cycle wins over the clear.
- R9: A push and a pop in the same cycle leave the occupancy unchanged and lose no data.
- R10: Words are read out in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Push request |
| wr_data_i | input | 32 | Packed pair {earlier, later} |
| full_o | output | 1 | FIFO holds DEPTH words |
| empty_o | output | 1 | FIFO holds no word |
| rd_en_i | input | 1 | Host read strobe |
| addr_i | input | 8 | Register offset |
| d32_i | input | 1 | 1: 32-bit access, 0: 16-bit access |
| rdata_o | output | 32 | Read data, one cycle after rd_en_i |
| rvalid_o | output | 1 | rdata_o valid |
| underflow_o | output | 1 | Sticky empty-read flag |
| uf_clr_i | input | 1 | Clear underflow_o |

## Verification
The bench repeats a 0x08 read to confirm the high half does not pop. A design that popped on both halves would skip every second channel pair. It reads past the end of the data to catch a design that wraps the pointer on an empty read or returns stale data. It overfills the FIFO, which exposes a design that overwrites the oldest word when full. It also pushes and pops in the same cycle, where a count update that handles only one side would lose a word or invent one.

// File: rtl/smp_pkg.sv
package smp_pkg;
  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_HI16,
    ACC_LO16,
    ACC_W32,
    ACC_BAD
  } acc_e;
endpackage

// File: rtl/smp_fifo_mem.sv
module smp_fifo_mem #(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              pop_i,
  output logic [WORD_W-1:0] head_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              push_acc, pop_acc;

  assign empty_o  = (cnt_q == '0);
  assign full_o   = (cnt_q == FULL_CNT);
  assign push_acc = push_i && !full_o;
  assign pop_acc  = pop_i && !empty_o;
  assign head_o   = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (push_acc) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_acc) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (pop_acc)  rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({push_acc, pop_acc})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  a_r2_no_push_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !pop_i) |=> full_o);
  a_r8_no_pop_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !pop_i);
  a_r9_push_pop_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !empty_o && !full_o) |=> $stable(cnt_q));
  a_r2_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_CNT);
endmodule

// File: rtl/smp_rd_decode.sv
module smp_rd_decode
  import smp_pkg::*;
#(
  parameter int               SMP_W  = 16,
  parameter int               ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFF_HI = 8'h08,
  parameter logic [ADDR_W-1:0] OFF_LO = 8'h0A
) (
  input  logic                rd_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                d32_i,
  input  logic                empty_i,
  input  logic [2*SMP_W-1:0]  head_i,
  output logic                pop_o,
  output logic                under_o,
  output logic [2*SMP_W-1:0]  rdata_o
);
  acc_e acc;

  always_comb begin
    acc = ACC_NONE;
    if (rd_en_i) begin
      if (addr_i == OFF_HI || addr_i == OFF_LO) begin
        if (d32_i)                 acc = ACC_W32;
        else if (addr_i == OFF_HI) acc = ACC_HI16;
        else                       acc = ACC_LO16;
      end else begin
        acc = ACC_BAD;
      end
    end
  end

  always_comb begin
    pop_o   = 1'b0;
    under_o = 1'b0;
    rdata_o = '0;
    if (acc inside {ACC_HI16, ACC_LO16, ACC_W32}) begin
      if (empty_i) begin
        under_o = 1'b1;
      end else begin
        // only the access that finishes a word pops it
        pop_o = (acc != ACC_HI16);
        case (acc)
          ACC_HI16: rdata_o = {{SMP_W{1'b0}}, head_i[2*SMP_W-1:SMP_W]};
          ACC_LO16: rdata_o = {{SMP_W{1'b0}}, head_i[SMP_W-1:0]};
          default:  rdata_o = head_i;
        endcase
      end
    end
  end

  // immediate checks on the decoder outputs
  always_comb begin
    if (rd_en_i && !d32_i && addr_i == OFF_HI)
      a_r3_hi_no_pop: assert (!pop_o);
    if (addr_i != OFF_HI && addr_i != OFF_LO)
      a_r6_bad_inert: assert (!pop_o && !under_o && rdata_o == '0);
  end
endmodule

// File: rtl/smp_fifo_rd_port.sv
module smp_fifo_rd_port #(
  parameter int                DEPTH  = 8,
  parameter int                SMP_W  = 16,
  parameter int                ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFF_HI = 8'h08,
  parameter logic [ADDR_W-1:0] OFF_LO = 8'h0A
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_valid_i,
  input  logic [2*SMP_W-1:0]  wr_data_i,
  output logic                full_o,
  output logic                empty_o,
  input  logic                rd_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                d32_i,
  output logic [2*SMP_W-1:0]  rdata_o,
  output logic                rvalid_o,
  output logic                underflow_o,
  input  logic                uf_clr_i
);
  localparam int WORD_W = 2 * SMP_W;

  logic              pop, under;
  logic [WORD_W-1:0] head, rdata_d;

  smp_fifo_mem #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (wr_valid_i),
    .wdata_i (wr_data_i),
    .pop_i   (pop),
    .head_o  (head),
    .empty_o (empty_o),
    .full_o  (full_o)
  );

  smp_rd_decode #(.SMP_W(SMP_W), .ADDR_W(ADDR_W), .OFF_HI(OFF_HI), .OFF_LO(OFF_LO)) u_dec (
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .d32_i   (d32_i),
    .empty_i (empty_o),
    .head_i  (head),
    .pop_o   (pop),
    .under_o (under),
    .rdata_o (rdata_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o    <= 1'b0;
      rdata_o     <= '0;
      underflow_o <= 1'b0;
    end else begin
      rvalid_o <= rd_en_i;
      rdata_o  <= rd_en_i ? rdata_d : '0;
      if (under)         underflow_o <= 1'b1;
      else if (uf_clr_i) underflow_o <= 1'b0;
    end
  end

  a_r7_rvalid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rvalid_o);
  a_r7_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> rdata_o == '0);
  a_r8_uf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underflow_o && !uf_clr_i) |=> underflow_o);
  a_r8_empty_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && empty_o) |=> rdata_o == '0);
  a_r6_bad_offset_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i != OFF_HI && addr_i != OFF_LO) |=> rdata_o == '0);
endmodule

// File: tb/smp_fifo_rd_port_bench.sv
`timescale 1ns/1ps
module smp_fifo_rd_port_bench;
  logic        clk = 0, rst_n = 0;
  logic        wr_valid = 0, rd_en = 0, d32 = 0, uf_clr = 0;
  logic [31:0] wr_data = '0;
  logic [7:0]  addr = '0;
  logic        full, empty, rvalid, underflow;
  logic [31:0] rdata;
  int          n_run = 0, n_fail = 0;
  logic [31:0] got;
  logic        got_v;

  always #2.5 clk = ~clk;

  smp_fifo_rd_port u_smp_fifo_rd_port (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .full_o(full), .empty_o(empty), .rd_en_i(rd_en), .addr_i(addr), .d32_i(d32),
    .rdata_o(rdata), .rvalid_o(rvalid), .underflow_o(underflow), .uf_clr_i(uf_clr)
  );

  // {addr, d32, expected rdata, expected empty after}
  localparam logic [41:0] VEC [7] = '{
    {8'h08, 1'b0, 32'h0000_8001, 1'b0},  // R3 high half
    {8'h08, 1'b0, 32'h0000_8001, 1'b0},  // R3 repeat, no advance
    {8'h0A, 1'b0, 32'h0000_7FFF, 1'b0},  // R4 low half pops
    {8'h04, 1'b0, 32'h0000_0000, 1'b0},  // R6 bad offset
    {8'h08, 1'b1, 32'h1234_FEDC, 1'b0},  // R5 32-bit at 0x08
    {8'h0A, 1'b1, 32'hA5A5_0F0F, 1'b0},  // R5 32-bit at 0x0A
    {8'h0A, 1'b0, 32'h0000_FFFF, 1'b1}   // R4/R10 last word
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    wr_valid = 1; wr_data = w;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic wide);
    rd_en = 1; addr = a; d32 = wide;
    @(negedge clk);
    got = rdata; got_v = rvalid;
    rd_en = 0;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 empty", 32'(empty), 1);
    chk("R1 full", 32'(full), 0);
    chk("R1 rvalid", 32'(rvalid), 0);
    chk("R1 rdata", rdata, 0);
    chk("R1 underflow", 32'(underflow), 0);
    rst_n = 1;
    @(negedge clk);

    push(32'h8001_7FFF); push(32'h1234_FEDC); push(32'hA5A5_0F0F); push(32'h0000_FFFF);
    chk("R2 not empty", 32'(empty), 0);
    for (int i = 0; i < 7; i++) begin
      rd(VEC[i][41:34], VEC[i][33]);
      chk($sformatf("R3-R6 vec%0d rdata", i), got, VEC[i][32:1]);
      chk($sformatf("R7 vec%0d rvalid", i), 32'(got_v), 1);
      chk($sformatf("R10 vec%0d empty", i), 32'(empty), 32'(VEC[i][0]));
    end
    chk("R6 no underflow", 32'(underflow), 0);

    // R7: idle cycle after a read
    @(negedge clk);
    chk("R7 rvalid drops", 32'(rvalid), 0);
    chk("R7 idle rdata", rdata, 0);

    // R8: empty read
    rd(8'h08, 1'b1);
    chk("R8 empty rdata", got, 0);
    chk("R8 underflow set", 32'(underflow), 1);
    @(negedge clk);
    chk("R8 sticky", 32'(underflow), 1);
    uf_clr = 1; @(negedge clk); uf_clr = 0;
    chk("R8 cleared", 32'(underflow), 0);

    // R2: fill, overfill, drain
    for (int i = 0; i < 8; i++) push(32'h1000_0000 + 32'(i));
    chk("R2 full", 32'(full), 1);
    push(32'hDEAD_BEEF);
    chk("R2 full after drop", 32'(full), 1);
    for (int i = 0; i < 8; i++) begin
      rd(8'h0A, 1'b1);
      chk($sformatf("R10 drain %0d", i), got, 32'h1000_0000 + 32'(i));
    end
    chk("R2 dropped word absent", 32'(empty), 1);
    rd(8'h0A, 1'b0);
    chk("R8 empty after drain", got, 0);
    uf_clr = 1; @(negedge clk); uf_clr = 0;

    // R9: push and pop together
    push(32'h1111_2222);
    wr_valid = 1; wr_data = 32'h3333_4444;
    rd(8'h08, 1'b1);
    wr_valid = 0;
    chk("R9 popped word", got, 32'h1111_2222);
    chk("R9 occupancy kept", 32'(empty), 0);
    rd(8'h08, 1'b1);
    chk("R9 pushed word", got, 32'h3333_4444);
    chk("R9 now empty", 32'(empty), 1);
    chk("R9 no underflow", 32'(underflow), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule